// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is the command front end of a byte-wide parallel NOR flash. It watches host write cycles (address, data, strobe) and decodes multi-cycle command sequences. Only a full unlock-and-set-up sequence makes the next write a program request. A second mode, entered through its own unlock sequence, lets each program take just two writes until the host leaves that mode. A program request starts an internal operation on a small byte array. The operation runs for a fixed number of clocks and needs no further help from the host.

While the operation runs, the ready output is low, every write is ignored, and reads return status instead of array data. Programming can only clear bits. The reset input aborts an operation at once and leaves the byte untouched. A test-only fill input stands in for erase and sets every byte to all ones.

Reads and writes are single-cycle strobes with no back-pressure. The block accepts every write strobe and silently drops those it does not honour. Each read strobe produces exactly one result, flagged by `rd_valid`, one clock later. The host must therefore take each read result in the cycle `rd_valid` is high.

Top module: `flash_cmd_iface`

## Requirements
- R1: After reset, `ready` is 1, no operation runs, the decoder is in read mode, and reads return array bytes.
- R2: The writes AAh at 555h, then 55h at 2AAh, then A0h at 555h, then any address with any data start one program operation. `ready` is 0 for exactly PROG_CYCLES clocks after the clock that takes the last write. The byte is updated when `ready` returns high.
- R3: While `ready` is 0, every write strobe is ignored, including complete command sequences.
- R4: When an operation ends, the decoder is back in read mode, so a lone address/data write changes nothing.
- R5: A program stores the old byte ANDed with the new data, so a 0 bit can never go back to 1.
- R6: The writes AAh at 555h, then 55h at 2AAh, then 20h at 555h enter bypass mode.
- R7: In bypass mode, data A0h at any address followed by an address/data write starts a program. This can be repeated with no unlock writes, and the decoder stays in bypass mode afterwards.
- R8: In bypass mode, every write other than A0h or 90h is ignored, including unlock writes, and the decoder stays in bypass mode.
- R9: In bypass mode, data 90h followed by data 00h returns the decoder to read mode. After that, A0h alone no longer leads to a program.
- R10: In the standard sequence, any write that does not match the next expected cycle returns the decoder to read mode.
- R11: A read taken while an operation runs returns bit 7 equal to the complement of bit 7 of the data being programmed. Bit 6 flips between successive such reads, and bits 5..0 read 0.
- R12: Driving `rst_n` low during an operation makes `ready` 1 at once, leaves the target byte unchanged, and returns to read mode.
- R13: A pulse on `erase_all` while idle sets every byte to FFh. While an operation runs, it is ignored.
- R14: A read strobe returns its result one clock later, with `rd_valid` high for that one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result: array byte, or status while busy |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| ready | output | 1 | 1 when idle, 0 while an operation runs |
| erase_all | input | 1 | Test-only fill of the whole array with FFh |

## Verification
The bench targets several corner cases, and each maps to a specific bug:
- Writes that land during an operation. A decoder that keeps listening would start a second program of a different byte.
- The exact length of the busy window. An off-by-one counter moves the edge where `ready` rises.
- Programming a 1 over a stored 0. A plain overwrite would show the 1.
- Foreign writes inside bypass mode. A decoder that drops back to read mode on them would then refuse the next two-cycle program.
- Status reads during an operation. The bench checks both the complemented top bit and the toggling bit.
- A reset mid-operation. The bench checks that the byte is not committed and that `ready` rises with no clock edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_PSET  = 3'd3,
    ST_BYP   = 3'd4,
    ST_BPSET = 3'd5,
    ST_BEXIT = 3'd6
  } cmd_state_e;

  localparam byte_t CMD_KEY_A   = 8'hAA;
  localparam byte_t CMD_KEY_B   = 8'h55;
  localparam byte_t CMD_PROGRAM = 8'hA0;
  localparam byte_t CMD_BYPASS  = 8'h20;
  localparam byte_t CMD_BEXIT_1 = 8'h90;
  localparam byte_t CMD_BEXIT_2 = 8'h00;

  localparam int KEY_ADDR_A = 'h555;
  localparam int KEY_ADDR_B = 'h2AA;

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic              busy,
  output logic              launch,
  output logic              in_bypass
);

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

  cmd_state_e state, nxt;
  logic take;
  logic key_a_hit, key_b_hit;

  assign take      = wr_en && !busy;
  assign key_a_hit = (wr_addr == ADDR_A) && (wr_data == CMD_KEY_A);
  assign key_b_hit = (wr_addr == ADDR_B) && (wr_data == CMD_KEY_B);

  always_comb begin
    nxt    = state;
    launch = 1'b0;
    if (take) begin
      case (state)
        ST_READ:  nxt = key_a_hit ? ST_UNL1 : ST_READ;
        ST_UNL1:  nxt = key_b_hit ? ST_UNL2 : ST_READ;
        ST_UNL2: begin
          if (wr_addr == ADDR_A && wr_data == CMD_PROGRAM)     nxt = ST_PSET;
          else if (wr_addr == ADDR_A && wr_data == CMD_BYPASS) nxt = ST_BYP;
          else                                                 nxt = ST_READ;
        end
        ST_PSET: begin
          launch = 1'b1;
          nxt    = ST_READ;
        end
        ST_BYP: begin
          if (wr_data == CMD_PROGRAM)      nxt = ST_BPSET;
          else if (wr_data == CMD_BEXIT_1) nxt = ST_BEXIT;
          else                             nxt = ST_BYP;
        end
        ST_BPSET: begin
          launch = 1'b1;
          nxt    = ST_BYP;
        end
        ST_BEXIT: nxt = (wr_data == CMD_BEXIT_2) ? ST_READ : ST_BYP;
        default:  nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_READ;
    else        state <= nxt;
  end

  assign in_bypass = (state == ST_BYP) || (state == ST_BPSET) || (state == ST_BEXIT);

  // R3: the engine's busy flag freezes the command decoder
  a_r3_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (state == $past(state)));

  // R6: bypass mode is only reached from the second unlock step with data 20h
  a_r6_bypass_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_bypass) |-> ($past(state) == ST_UNL2 && $past(wr_data) == CMD_BYPASS));

  // R9: bypass mode is left only through the 90h/00h pair
  a_r9_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_bypass) |-> ($past(state) == ST_BEXIT && $past(wr_data) == CMD_BEXIT_2));

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PROG_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  byte_t             launch_data,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] op_addr,
  output byte_t             op_data
);

  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign commit = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else if (!busy) begin
      if (launch) begin
        busy    <= 1'b1;
        cnt     <= CNT_LOAD;
        op_addr <= launch_addr;
        op_data <= launch_data;
      end
    end else if (commit) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2: an accepted request makes the engine busy on the next cycle
  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R3: the decoder never issues a request while the engine runs
  a_r3_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  // R4: an idle engine stays idle without a request
  a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> !busy);

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  byte_t             commit_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_byte
);

  localparam int DEPTH = 1 << ADDR_W;

  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      mem[commit_addr] <= mem[commit_addr] & commit_data;
    end
  end

  assign rd_byte = mem[rd_addr];

  // R5: a commit only clears bits of the stored byte
  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !erase) |=> (mem[$past(commit_addr)] == ($past(mem[commit_addr]) & $past(commit_data))));

endmodule

// File: rtl/flash_read_port.sv
module flash_read_port
  import flash_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  logic  busy,
  input  logic  op_bit7,
  input  byte_t arr_byte,
  output byte_t rd_data,
  output logic  rd_valid
);

  logic toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      toggle   <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (busy) begin
          rd_data <= {~op_bit7, toggle, 6'b0};
          toggle  <= ~toggle;
        end else begin
          rd_data <= arr_byte;
        end
      end
    end
  end

  // R11: status bit 7 is the complement of the byte being programmed
  a_r11_dq7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[7] == ~$past(op_bit7)));

  // R11: bit 6 differs between back-to-back status reads
  a_r11_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en) && $past(busy)) |=> (rd_data[6] != $past(rd_data[6])));

endmodule

// File: rtl/flash_cmd_iface.sv
module flash_cmd_iface
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PROG_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              ready,
  input  logic              erase_all
);

  logic              launch, in_bypass, busy, commit;
  logic [ADDR_W-1:0] op_addr;
  byte_t             op_data, arr_byte;

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .launch    (launch),
    .in_bypass (in_bypass)
  );

  flash_prog_engine #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_addr (wr_addr),
    .launch_data (wr_data),
    .busy        (busy),
    .commit      (commit),
    .op_addr     (op_addr),
    .op_data     (op_data)
  );

  flash_byte_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase       (erase_all && !busy),
    .commit      (commit),
    .commit_addr (op_addr),
    .commit_data (op_data),
    .rd_addr     (rd_addr),
    .rd_byte     (arr_byte)
  );

  flash_read_port u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .busy     (busy),
    .op_bit7  (op_data[7]),
    .arr_byte (arr_byte),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign ready = !busy;

  // R12: with reset low the block reports ready
  a_r12_reset_ready: assert property (@(posedge clk) !rst_n |-> ready);

  // R1: the decoder leaves reset outside bypass mode
  a_r1_reset_mode: assert property (@(posedge clk) $rose(rst_n) |-> !in_bypass);

endmodule

// File: tb/tb_flash_cmd_iface.sv
module tb_flash_cmd_iface;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam int PROG       = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        rd_data;
  logic              rd_valid;
  logic              ready;
  logic              erase_all = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q [$];
  logic [7:0] mask_q [$];
  string      tag_q [$];
  logic [7:0] last_q = '0;
  logic [7:0] prev_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_iface #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .ready(ready), .erase_all(erase_all)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R14 unexpected read result actual=%0h expected=none", rd_data);
      end else begin
        logic [7:0] e, m;
        string t;
        e = exp_q.pop_front();
        m = mask_q.pop_front();
        t = tag_q.pop_front();
        if ((rd_data & m) !== (e & m)) begin
          fails++;
          $display("FAIL %s actual=%0h expected=%0h", t, rd_data & m, e & m);
        end
      end
      prev_q = last_q;
      last_q = rd_data;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input int m, input string tag);
    @(negedge clk);
    exp_q.push_back(8'(e)); mask_q.push_back(8'(m)); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_erase();
    @(negedge clk); erase_all = 1'b1;
    @(negedge clk); erase_all = 1'b0;
  endtask

  task automatic std_prog(input int a, input int d);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!ready && n < 200) begin @(negedge clk); n++; end
    chk(ready, tag, ready, 1);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(ready == 1'b1, tag, ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && rd_valid == 1'b0, "R1 reset state", {ready, rd_valid}, 2);
    rst_n = 1'b1;
    pulse_erase();
    rd('h000, 'hFF, 'hFF, "R13 fill sets FF");
    rd('h7FF, 'hFF, 'hFF, "R1 read mode returns array");

    // R2: exact busy window
    std_prog('h010, 'h5A);
    chk(ready == 1'b0, "R2 busy after last write", ready, 0);
    repeat (PROG - 1) @(negedge clk);
    chk(ready == 1'b0, "R2 busy on final cycle", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R2 ready after window", ready, 1);
    rd('h010, 'h5A, 'hFF, "R2 programmed byte");

    // R11, R3, R13 during busy
    std_prog('h011, 'h3C);
    rd('h011, 'h80, 'hBF, "R11 status dq7 complement");
    rd('h011, 'h80, 'hBF, "R11 status second read");
    @(negedge clk);
    chk(last_q[6] != prev_q[6], "R11 dq6 toggles", last_q[6], ~prev_q[6]);
    std_prog('h020, 'h00);
    pulse_erase();
    wait_ready("R3 op finishes");
    rd('h011, 'h3C, 'hFF, "R13 fill ignored while busy");
    rd('h020, 'hFF, 'hFF, "R3 busy writes ignored");

    // R4: back in read mode after the operation
    wr('h010, 'h00);
    idle_check("R4 lone write starts nothing");
    rd('h010, 'h5A, 'hFF, "R4 byte unchanged");

    // R5: AND semantics
    std_prog('h010, 'hF0);
    wait_ready("R5 op finishes");
    rd('h010, 'h50, 'hFF, "R5 zero bits stay zero");

    // R10: broken sequences fall back to read mode
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h77); wr('h012, 'h00);
    idle_check("R10 bad set-up command");
    wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr('h012, 'h00);
    idle_check("R10 bad unlock address");
    rd('h012, 'hFF, 'hFF, "R10 byte unchanged");

    // R6, R7: bypass programs
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h20);
    idle_check("R6 bypass entry starts nothing");
    wr('h000, 'hA0); wr('h030, 'h3C);
    chk(ready == 1'b0, "R7 bypass program starts", ready, 0);
    wait_ready("R7 first op finishes");
    wr('h7FF, 'hA0); wr('h031, 'hC3);
    chk(ready == 1'b0, "R7 repeated bypass program", ready, 0);
    wait_ready("R7 second op finishes");
    rd('h030, 'h3C, 'hFF, "R7 first byte");
    rd('h031, 'hC3, 'hFF, "R7 second byte");

    // R8: foreign writes ignored inside bypass
    wr('h032, 'h12);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h033, 'h77);
    idle_check("R8 foreign writes start nothing");
    rd('h032, 'hFF, 'hFF, "R8 byte untouched");
    wr('h000, 'hA0); wr('h033, 'h11);
    chk(ready == 1'b0, "R8 still in bypass", ready, 0);
    wait_ready("R8 op finishes");
    rd('h033, 'h11, 'hFF, "R8 bypass program after foreign writes");

    // R9: leave bypass
    wr('h000, 'h90); wr('h000, 'h00);
    wr('h555, 'hA0); wr('h034, 'h44);
    idle_check("R9 A0 no longer programs");
    rd('h034, 'hFF, 'hFF, "R9 byte unchanged");

    // R12: reset aborts an operation
    std_prog('h040, 'h0F);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R12 busy before reset", ready, 0);
    rst_n = 1'b0;
    #1;
    chk(ready == 1'b1, "R12 ready at once", ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    rd('h040, 'hFF, 'hFF, "R12 byte not committed");
    wr('h040, 'h00);
    idle_check("R12 read mode after abort");

    // R14: one result per strobe, one cycle later
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ADDR_W'('h010);
    exp_q.push_back(8'h50); mask_q.push_back(8'hFF); tag_q.push_back("R14 latency");
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, "R14 valid one cycle later", rd_valid, 1);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R14 valid for one cycle", rd_valid, 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R14 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule